// File: doc/BRIEF.md
# Dual-Width CRC Engine

This block computes a cyclic redundancy check over a stream of 32-bit data words. It switches at run time between a 16-bit remainder on polynomial 0x1021 and a 32-bit remainder on polynomial 0x04C11DB7. Each accepted word is broken into four bytes, one byte per clock. The bytes are taken most-significant-first or least-significant-first, and each byte enters the remainder starting from its bit 7 or from its bit 0.

A seed register can be written at any time and copied into the running remainder with a one-cycle load pulse. The result port shows the remainder continuously, after three optional steps in this order:
1. bit reflection across the active width;
2. a complement of the active width (final XOR);
3. a reversal of all four bytes of the 32-bit result.

The running remainder itself is never altered by these output steps. All settings are plain input ports, so software or a surrounding controller drives them directly.

Top module: `crc_engine`

## Requirements
- R1: Immediately after reset, with every configuration input at 0, `crc_out` reads 0x0000FFFF and `in_ready` is 1. The internal remainder holds 0xFFFFFFFF after reset, so switching `cfg_wide` to 1 with no other change reads 0xFFFFFFFF.
- R2: With `cfg_wide`=0 the remainder is 16 bits wide and uses polynomial 0x1021 in left-shifting form. Seed 0xFFFF, MSB-first input and plain output give 0x29B1 for the ASCII bytes "123456789", in bits 15:0 with bits 31:16 at zero.
- R3: With `cfg_wide`=1 the remainder is 32 bits wide and uses polynomial 0x04C11DB7 in left-shifting form. Seed 0xFFFFFFFF, LSB-first input, reflected output and final XOR give 0xCBF43926 for "123456789".
- R4: A one-cycle `seed_load` copies the seed register into the remainder, which is visible in the next cycle. With `cfg_wide`=0 only seed bits 15:0 are taken.
- R5: `seed_wr` stores `seed_din` into the seed register without touching the remainder. After reset the seed register holds 0xFFFFFFFF.
- R6: With `cfg_in_le`=0 a word is consumed from bits 31:24 down to bits 7:0. With `cfg_in_le`=1 the order is bits 7:0 first, up to bits 31:24.
- R7: With `cfg_in_lsb`=1 each byte is fed starting at its bit 0. Big-endian word 0x8552AB01 therefore gives the same remainder as MSB-first word 0xA14AD580. With 0 each byte starts at bit 7.
- R8: `cfg_out_xor`=1 complements the active width of the result (0xFFFF or 0xFFFFFFFF). It acts on the output only, so later words accumulate as if it were off.
- R9: `cfg_out_lsb`=1 reverses the bit order of the result across the active width (16 or 32 bits), before the XOR and the byte swap.
- R10: `cfg_out_swap`=1 reverses the four bytes of the 32-bit result in both modes. The 16-bit CRC therefore appears byte-reversed in bits 31:16, with bits 15:0 at zero (0x29B1 reads 0xB1290000).
- R11: A word is taken on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 for exactly three cycles, and the result of that word is complete when `in_ready` returns to 1.
- R12: When no word is in progress and `seed_load` is 0, the remainder holds its value. This includes cycles in which only the seed register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | 0: 16-bit remainder, poly 0x1021; 1: 32-bit remainder, poly 0x04C11DB7 |
| cfg_in_le | input | 1 | 1: consume bytes of a word from least significant first |
| cfg_in_lsb | input | 1 | 1: feed each byte starting at bit 0 |
| cfg_out_lsb | input | 1 | 1: bit-reflect the result over the active width |
| cfg_out_xor | input | 1 | 1: complement the active width of the result |
| cfg_out_swap | input | 1 | 1: reverse the four bytes of the 32-bit result |
| seed_wr | input | 1 | Write `seed_din` into the seed register |
| seed_din | input | 32 | Seed value to store |
| seed_load | input | 1 | Copy the seed register into the remainder |
| in_valid | input | 1 | Data word offered |
| in_ready | output | 1 | Engine can take a word this cycle |
| in_data | input | 32 | Data word |
| crc_out | output | 32 | Formatted result |

## Verification
The assertions take for granted that `seed_load` is never raised while a word is still being consumed, and that `cfg_wide`, `cfg_in_le` and `cfg_in_lsb` hold steady from the acceptance of a word until `in_ready` returns. The stimulus keeps within this rule in two ways:
- it changes configuration and pulses the seed load only while the engine is idle;
- it drops `in_valid` right after each acceptance and waits for `in_ready` before doing anything else.

Output-side settings act combinationally and are changed freely between checks.

// File: rtl/crc_pkg.sv
package crc_pkg;

  localparam int          CRC_W  = 32;
  localparam logic [31:0] POLY_W = 32'h04C1_1DB7;
  localparam logic [15:0] POLY_N = 16'h1021;

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  function automatic logic [15:0] rev16(input logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[15-i];
    return r;
  endfunction

  // Eight unrolled left-shift steps; d is consumed from bit 7 down to bit 0.
  function automatic logic [31:0] step_byte(input logic [31:0] rem,
                                            input logic [7:0]  d,
                                            input logic        wide);
    logic [31:0] r;
    logic        fb;
    r = rem;
    for (int i = 7; i >= 0; i--) begin
      fb = (wide ? r[31] : r[15]) ^ d[i];
      r  = r << 1;
      if (fb) r = r ^ (wide ? POLY_W : {16'h0, POLY_N});
    end
    if (!wide) r[31:16] = 16'h0;
    return r;
  endfunction

  function automatic logic [31:0] width_mask(input logic wide);
    return wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  // Reflect, then complement, then byte-reverse.
  function automatic logic [31:0] shape_out(input logic [31:0] rem,
                                            input logic wide, input logic refl,
                                            input logic cpl,  input logic swap);
    logic [31:0] v;
    v = rem & width_mask(wide);
    if (refl) v = wide ? rev32(v) : {16'h0, rev16(v[15:0])};
    if (cpl)  v = v ^ width_mask(wide);
    if (swap) v = {v[7:0], v[15:8], v[23:16], v[31:24]};
    return v;
  endfunction

endpackage

// File: rtl/crc_word_feeder.sv
module crc_word_feeder #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              byte_le,
  output logic              in_ready,
  output logic              byte_vld,
  output logic [7:0]        byte_out
);
  localparam int NBYTES = DATA_W / 8;
  localparam int CNT_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES - 1);

  logic              busy;
  logic [CNT_W-1:0]  idx;
  logic [DATA_W-1:0] word_q;
  logic              accept;
  logic [CNT_W-1:0]  sel;
  logic [DATA_W-1:0] src;

  assign in_ready = !busy;
  assign accept   = in_valid && !busy;
  assign byte_vld = accept || busy;
  assign sel      = accept ? '0 : idx;
  assign src      = accept ? in_data : word_q;

  always_comb begin
    byte_out = '0;
    for (int k = 0; k < NBYTES; k++) begin
      if (CNT_W'(k) == sel)
        byte_out = byte_le ? src[8*k +: 8] : src[DATA_W-8-8*k +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx    <= '0;
      word_q <= '0;
    end else if (accept) begin
      word_q <= in_data;
      if (NBYTES > 1) begin
        busy <= 1'b1;
        idx  <= CNT_W'(1);
      end
    end else if (busy) begin
      if (idx == LAST) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  assert_ready_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  assert_ready_back_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx == LAST) |=> in_ready);
  assert_word_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx != LAST) |=> $stable(word_q));

endmodule

// File: rtl/crc_remainder.sv
module crc_remainder
  import crc_pkg::*;
#(
  parameter logic [31:0] SEED_RST = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wide,
  input  logic        lsb_in,
  input  logic        seed_wr,
  input  logic [31:0] seed_din,
  input  logic        seed_load,
  input  logic        byte_vld,
  input  logic [7:0]  byte_in,
  output logic [31:0] rem_q
);
  logic [31:0] seed_q;
  logic [7:0]  byte_ord;
  logic [31:0] rem_next;

  assign byte_ord = lsb_in ? rev8(byte_in) : byte_in;
  assign rem_next = step_byte(rem_q, byte_ord, wide);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seed_q <= SEED_RST;
    else if (seed_wr) seed_q <= seed_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rem_q <= 32'hFFFF_FFFF;
    else if (seed_load)  rem_q <= seed_q & width_mask(wide);
    else if (byte_vld)   rem_q <= rem_next;
  end

  assert_seed_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> rem_q == ($past(wide) ? $past(seed_q) : {16'h0, $past(seed_q[15:0])}));
  assert_rem_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_load && !byte_vld) |=> $stable(rem_q));
  assert_narrow_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && (seed_load || byte_vld)) |=> rem_q[31:16] == 16'h0);

endmodule

// File: rtl/crc_result_fmt.sv
module crc_result_fmt
  import crc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] rem_q,
  input  logic        wide,
  input  logic        refl,
  input  logic        cpl,
  input  logic        swap,
  output logic [31:0] crc_out
);
  assign crc_out = shape_out(rem_q, wide, refl, cpl, swap);

  assert_swap_place_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && swap) |-> crc_out[15:0] == 16'h0);
  assert_narrow_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && !swap) |-> crc_out[31:16] == 16'h0);

endmodule

// File: rtl/crc_engine.sv
module crc_engine #(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] SEED_RST = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wide,
  input  logic              cfg_in_le,
  input  logic              cfg_in_lsb,
  input  logic              cfg_out_lsb,
  input  logic              cfg_out_xor,
  input  logic              cfg_out_swap,
  input  logic              seed_wr,
  input  logic [31:0]       seed_din,
  input  logic              seed_load,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic [31:0]       crc_out
);
  logic        byte_vld;
  logic [7:0]  byte_cur;
  logic [31:0] rem_q;

  crc_word_feeder #(.DATA_W(DATA_W)) u_feed (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .byte_le(cfg_in_le), .in_ready(in_ready), .byte_vld(byte_vld),
    .byte_out(byte_cur)
  );

  crc_remainder #(.SEED_RST(SEED_RST)) u_rem (
    .clk(clk), .rst_n(rst_n), .wide(cfg_wide), .lsb_in(cfg_in_lsb),
    .seed_wr(seed_wr), .seed_din(seed_din), .seed_load(seed_load),
    .byte_vld(byte_vld), .byte_in(byte_cur), .rem_q(rem_q)
  );

  crc_result_fmt u_fmt (
    .clk(clk), .rst_n(rst_n), .rem_q(rem_q), .wide(cfg_wide),
    .refl(cfg_out_lsb), .cpl(cfg_out_xor), .swap(cfg_out_swap),
    .crc_out(crc_out)
  );

  assert_load_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |-> in_ready);

endmodule

// File: tb/crc_engine_tb.sv
module crc_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wide = 0, cfg_in_le = 0, cfg_in_lsb = 0;
  logic        cfg_out_lsb = 0, cfg_out_xor = 0, cfg_out_swap = 0;
  logic        seed_wr = 0, seed_load = 0, in_valid = 0;
  logic [31:0] seed_din = '0, in_data = '0;
  logic        in_ready;
  logic [31:0] crc_out;

  always #10 clk = ~clk;

  crc_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_in_le(cfg_in_le),
    .cfg_in_lsb(cfg_in_lsb), .cfg_out_lsb(cfg_out_lsb), .cfg_out_xor(cfg_out_xor),
    .cfg_out_swap(cfg_out_swap), .seed_wr(seed_wr), .seed_din(seed_din),
    .seed_load(seed_load), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .crc_out(crc_out)
  );

  typedef struct { logic [31:0] val; string tag; } exp_t;
  exp_t q[$];
  event chk_ev;
  int   n_vec = 0, n_bad = 0;
  logic [31:0] m_rem  = 32'hFFFF_FFFF;
  logic [31:0] m_seed = 32'hFFFF_FFFF;

  // Bit-serial reference: one generator bit at a time.
  function automatic logic [31:0] ref_byte(input logic [31:0] r, input logic [7:0] b,
                                           input logic w, input logic lsb);
    logic bit_in, top;
    for (int j = 0; j < 8; j++) begin
      bit_in = lsb ? b[j] : b[7-j];
      if (w) begin
        top = r[31];
        r   = {r[30:0], 1'b0};
        if (top != bit_in) r = r ^ 32'h04C11DB7;
      end else begin
        top = r[15];
        r[15:0] = {r[14:0], 1'b0};
        if (top != bit_in) r[15:0] = r[15:0] ^ 16'h1021;
        r[31:16] = 16'h0;
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_word(input logic [31:0] r, input logic [31:0] wd,
                                           input logic w, input logic le, input logic lsb);
    logic [7:0] b;
    for (int k = 0; k < 4; k++) begin
      b = le ? wd[8*k +: 8] : wd[8*(3-k) +: 8];
      r = ref_byte(r, b, w, lsb);
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_view(input logic [31:0] r);
    logic [31:0] v, t;
    int n;
    n = cfg_wide ? 32 : 16;
    v = cfg_wide ? r : (r & 32'hFFFF);
    if (cfg_out_lsb) begin
      t = '0;
      for (int i = 0; i < n; i++) t[n-1-i] = v[i];
      v = t;
    end
    if (cfg_out_xor) v = ~v & (cfg_wide ? 32'hFFFF_FFFF : 32'hFFFF);
    if (cfg_out_swap) v = {v[7:0], v[15:8], v[23:16], v[31:24]};
    return v;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_val(input logic [31:0] v, input string tag);
    exp_t e;
    e.val = v; e.tag = tag;
    q.push_back(e);
    -> chk_ev;
    #2;
  endtask

  task automatic expect_model(input string tag);
    expect_val(ref_view(m_rem), tag);
  endtask

  // Monitor: pops the scoreboard and compares with the live output.
  initial begin
    exp_t e;
    forever begin
      @(chk_ev);
      #1;
      if (q.size() != 0) begin
        e = q.pop_front();
        check(crc_out === e.val, e.tag, crc_out, e.val);
      end
    end
  end

  task automatic set_cfg(input logic w, le, lsb, olsb, oxor, sw);
    @(negedge clk);
    cfg_wide = w; cfg_in_le = le; cfg_in_lsb = lsb;
    cfg_out_lsb = olsb; cfg_out_xor = oxor; cfg_out_swap = sw;
  endtask

  task automatic write_seed(input logic [31:0] v);
    @(negedge clk); seed_wr = 1; seed_din = v;
    @(negedge clk); seed_wr = 0;
    m_seed = v;
  endtask

  task automatic load_seed();
    @(negedge clk); seed_load = 1;
    @(negedge clk); seed_load = 0;
    m_rem = cfg_wide ? m_seed : (m_seed & 32'hFFFF);
  endtask

  task automatic send_word(input logic [31:0] wd);
    int gap;
    @(negedge clk);
    check(in_ready === 1'b1, "R11 ready before word", {31'h0, in_ready}, 32'h1);
    in_valid = 1; in_data = wd;
    @(negedge clk);
    in_valid = 0;
    gap = 0;
    while (in_ready !== 1'b1 && gap < 10) begin
      gap++;
      @(negedge clk);
    end
    check(gap == 3, "R11 ready gap", 32'(gap), 32'd3);
    m_rem = ref_word(m_rem, wd, cfg_wide, cfg_in_le, cfg_in_lsb);
  endtask

  task automatic finish_run();
    #5;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    logic [31:0] v_a;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check(in_ready === 1'b1, "R1 ready after reset", {31'h0, in_ready}, 32'h1);
    expect_val(32'h0000_FFFF, "R1 narrow view after reset");
    set_cfg(1, 0, 0, 0, 0, 0);
    expect_val(32'hFFFF_FFFF, "R1 full remainder after reset");
    // R5: seed reset value reaches the remainder
    load_seed();
    expect_val(32'hFFFF_FFFF, "R5 seed reset value");

    // R2: 16-bit standard check via seed primed with "1"
    set_cfg(0, 0, 0, 0, 0, 0);
    write_seed(ref_byte(32'hFFFF, 8'h31, 1'b0, 1'b0));
    load_seed();
    expect_model("R4 load narrow seed");
    send_word(32'h3233_3435);
    send_word(32'h3637_3839);
    expect_val(32'h0000_29B1, "R2 check value 16-bit");
    // R10 / R9 / R8 output shaping
    set_cfg(0, 0, 0, 0, 0, 1);
    expect_val(32'hB129_0000, "R10 swap places 16-bit crc high");
    set_cfg(0, 0, 0, 1, 0, 0);
    expect_model("R9 reflect 16-bit");
    set_cfg(0, 0, 0, 1, 1, 0);
    expect_model("R8 complement after reflect");
    set_cfg(0, 0, 0, 0, 0, 0);
    expect_val(32'h0000_29B1, "R8 remainder untouched by xor");

    // R3 / R7: 32-bit standard check
    set_cfg(1, 0, 1, 1, 1, 0);
    write_seed(ref_byte(32'hFFFF_FFFF, 8'h31, 1'b1, 1'b1));
    load_seed();
    send_word(32'h3233_3435);
    send_word(32'h3637_3839);
    expect_val(32'hCBF4_3926, "R3 check value 32-bit");
    set_cfg(1, 0, 1, 1, 1, 1);
    expect_val(32'h2639_F4CB, "R10 swap 32-bit");

    // R6: byte order
    set_cfg(1, 1, 0, 0, 0, 0);
    write_seed(32'hFFFF_FFFF);
    load_seed();
    send_word(32'h8552_AB01);
    expect_model("R6 little-endian bytes");
    v_a = m_rem;
    load_seed();
    set_cfg(1, 0, 0, 0, 0, 0);
    send_word(32'h01AB_5285);
    expect_val(v_a, "R6 LE equals reversed BE");

    // R7: LSB-first stream equals the reversed-bit word fed MSB-first
    set_cfg(1, 0, 1, 0, 0, 0);
    load_seed();
    send_word(32'h8552_AB01);
    expect_model("R7 lsb-first input");
    v_a = m_rem;
    set_cfg(1, 0, 0, 0, 0, 0);
    load_seed();
    send_word(32'hA14A_D580);
    expect_val(v_a, "R7 serial bit stream equivalence");

    // R8: xor does not feed back into accumulation
    set_cfg(0, 0, 0, 0, 1, 0);
    load_seed();
    send_word(32'hDEAD_BEEF);
    expect_model("R8 xor on first word");
    send_word(32'h0123_4567);
    expect_model("R8 xor second word accumulates raw");

    // R12: idle and seed writes leave remainder alone
    set_cfg(1, 0, 0, 0, 0, 0);
    expect_model("R12 before idle");
    repeat (5) @(negedge clk);
    write_seed(32'h1234_ABCD);
    expect_model("R12 hold across idle and seed write");

    // R4: narrow load takes only low half of seed
    set_cfg(0, 0, 0, 0, 0, 0);
    load_seed();
    expect_val(32'h0000_ABCD, "R4 narrow load low half");
    set_cfg(1, 0, 0, 0, 0, 0);
    load_seed();
    expect_val(32'h1234_ABCD, "R4 wide load full seed");

    finish_run();
  end

endmodule